// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

A synchronous dual-port memory with 18,432 bits of storage. Two ports, A and B, access the same storage through separate enable, write-enable, address and data pins. Each port picks its own word width at elaboration time from the set 1, 2, 4, 9, 18 and 36 bits. The address width follows from that choice, so every port covers all 16,384 data bits. The 9-, 18- and 36-bit widths also carry parity bits. The narrower widths have no parity and never reach those bits.

Inside, the storage is 512 rows of 36 bits: 32 data bits and 4 parity bits per row. A narrow port splits its address into a row index and a slice index, and reads or writes one slice of that row. This lets one port fill a buffer in wide words while the other drains it in narrow pieces, with no packing logic in the user's design. Both ports share one clock. Both may work in the same cycle. Reads are registered and read-first.

Top module: `mixw_dpram`

## Requirements
- R1: WIDTH_A and WIDTH_B are each one of 1, 2, 4, 9, 18 or 36. The data part of a word is the width itself for widths up to 4, and 8, 16 or 32 bits for 9, 18 or 36. The address has 9 + log2(32 / data bits) bits. Width 36 therefore has 9 address bits, width 9 has 11 and width 2 has 13, and the top address of each port is usable.
- R2: A row holds its data in bits [31:0] and its parity in bits [35:32]. For a port with d data bits, the row index is the address shifted right by log2(32/d). The remaining low address bits give a slice s, which occupies row bits [s*d +: d]. Slice 0 is the least significant slice.
- R3: For widths 9, 18 and 36, the port word carries data in its low d bits and parity in its upper 1, 2 or 4 bits. The parity of slice s lives in row bits [32 + s*p +: p], where p is the number of parity bits.
- R4: A port acts only on a rising clock edge with its enable high. Read data shows on its rdata output after that edge and stays until the port's next enabled edge.
- R5: With its enable low, a port writes nothing, whatever its write enable, and its rdata does not change.
- R6: An enabled write returns on the same port's rdata the content the addressed word held before the write (read-first).
- R7: When one port reads bits that the other port writes in the same cycle, the reading port returns the old content.
- R8: A port of width 1, 2 or 4 neither changes nor shows the parity bits.
- R9: A synchronous active-high rst forces both rdata outputs to zero at the next edge and leaves the stored content untouched.
- R10: Both ports may write in the same cycle, and writes to disjoint bits both take effect. If the two writes touch the same bits, the stored value is undefined, and callers must avoid it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | WIDTH_A | Port A write word |
| a_rdata | output | WIDTH_A | Port A registered read word |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | WIDTH_B | Port B write word |
| b_rdata | output | WIDTH_B | Port B registered read word |

## Verification
The bench runs a 36-bit port against a 9-bit port and reads every 9-bit slice of a row. A design that reversed the slice order, or that dropped parity into the wrong bit, would return bytes swapped end for end or with the ninth bit wrong. It issues writes on a disabled port and a same-cycle write on one port with a read on the other. A design that ignored the enable would change memory, and one that forwarded new data would return the written value where the old one is due. A second instance pairs 36 bits with 2 bits, showing that a parityless slice write keeps all four parity bits and lands in exactly two data bits. It also checks that reset clears the outputs but not the contents.

// File: rtl/mixw_pkg.sv
package mixw_pkg;
  localparam int ROW_DATA_W = 32;
  localparam int ROW_PAR_W  = 4;
  localparam int ROW_W      = ROW_DATA_W + ROW_PAR_W;
  localparam int ROW_CNT    = 512;
  localparam int ROW_AW     = $clog2(ROW_CNT);

  function automatic int data_bits(input int w);
    return (w >= 9) ? (w - w / 9) : w;
  endfunction

  function automatic int par_bits(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction

  function automatic int slice_cnt(input int w);
    return ROW_DATA_W / data_bits(w);
  endfunction

  function automatic int sel_bits(input int w);
    return $clog2(slice_cnt(w));
  endfunction

  function automatic int addr_bits(input int w);
    return ROW_AW + sel_bits(w);
  endfunction
endpackage

// File: rtl/mixw_lane.sv
module mixw_lane import mixw_pkg::*; #(
  parameter int W = 9,
  localparam int AW = addr_bits(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wdata,
  input  logic [ROW_W-1:0]  row_q,
  output logic [ROW_AW-1:0] row_idx,
  output logic [ROW_W-1:0]  row_mask,
  output logic [ROW_W-1:0]  row_val,
  output logic [W-1:0]      rdata
);
  localparam int DW = data_bits(W);
  localparam int PW = par_bits(W);
  localparam int SB = sel_bits(W);
  localparam int SW = (SB > 0) ? SB : 1;

  logic [SW-1:0]    sel;
  logic [SW-1:0]    sel_q;
  logic [ROW_W-1:0] dat_mask, dat_val, par_mask, par_val;
  logic [DW-1:0]    dat_rd;

  // split the address into row index and slice index
  generate
    if (SB > 0) begin : g_sel
      assign sel     = addr[SB-1:0];
      assign row_idx = addr[AW-1:SB];
    end else begin : g_nosel
      assign sel     = '0;
      assign row_idx = addr;
    end
  endgenerate

  // slice index follows the read register of the shared store
  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (en) sel_q <= sel;
  end

  always_comb begin
    dat_mask = ROW_W'({DW{1'b1}}) << (int'(sel) * DW);
    dat_val  = ROW_W'(wdata[DW-1:0]) << (int'(sel) * DW);
    dat_rd   = DW'(row_q >> (int'(sel_q) * DW));
  end

  generate
    if (PW > 0) begin : g_par
      logic [PW-1:0] par_rd;
      assign par_mask = ROW_W'({PW{1'b1}}) << (ROW_DATA_W + int'(sel) * PW);
      assign par_val  = ROW_W'(wdata[W-1:DW]) << (ROW_DATA_W + int'(sel) * PW);
      assign par_rd   = PW'(row_q[ROW_W-1:ROW_DATA_W] >> (int'(sel_q) * PW));
      assign rdata    = {par_rd, dat_rd};
    end else begin : g_nopar
      assign par_mask = '0;
      assign par_val  = '0;
      assign rdata    = dat_rd;
    end
  endgenerate

  assign row_mask = dat_mask | par_mask;
  assign row_val  = dat_val | par_val;

  AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(row_mask) == W)); // R2
endmodule

// File: rtl/mixw_store.sv
module mixw_store import mixw_pkg::*; #(
  parameter int ROWS = ROW_CNT,
  parameter int RW   = ROW_W,
  localparam int RAW = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           a_rd,
  input  logic           a_wr,
  input  logic [RAW-1:0] a_row,
  input  logic [RW-1:0]  a_mask,
  input  logic [RW-1:0]  a_val,
  output logic [RW-1:0]  a_q,
  input  logic           b_rd,
  input  logic           b_wr,
  input  logic [RAW-1:0] b_row,
  input  logic [RW-1:0]  b_mask,
  input  logic [RW-1:0]  b_val,
  output logic [RW-1:0]  b_q
);
  logic [RW-1:0] mem [ROWS];

  // bit-masked writes from both ports
  always_ff @(posedge clk) begin
    for (int i = 0; i < RW; i++) begin
      if (a_wr && a_mask[i]) mem[a_row][i] <= a_val[i];
      if (b_wr && b_mask[i]) mem[b_row][i] <= b_val[i];
    end
  end

  // read-first output registers with synchronous reset
  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_rd) a_q <= mem[a_row];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_q <= '0;
    else if (b_rd) b_q <= mem[b_row];
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (a_q == '0 && b_q == '0)); // R9
  AST_IDLE_HOLDS_A: assert property (@(posedge clk) disable iff (rst)
    !a_rd |=> $stable(a_q)); // R5
  AST_IDLE_HOLDS_B: assert property (@(posedge clk) disable iff (rst)
    !b_rd |=> $stable(b_q)); // R5
  AST_WRITE_LANDS_A: assert property (@(posedge clk) disable iff (rst)
    (a_wr && !(b_wr && b_row == a_row)) |=>
      ((mem[$past(a_row)] & $past(a_mask)) == ($past(a_val) & $past(a_mask)))); // R10
  AST_WRITE_LANDS_B: assert property (@(posedge clk) disable iff (rst)
    (b_wr && !(a_wr && a_row == b_row)) |=>
      ((mem[$past(b_row)] & $past(b_mask)) == ($past(b_val) & $past(b_mask)))); // R10
endmodule

// File: rtl/mixw_dpram.sv
module mixw_dpram import mixw_pkg::*; #(
  parameter int WIDTH_A = 36,
  parameter int WIDTH_B = 9,
  localparam int A_AW = addr_bits(WIDTH_A),
  localparam int B_AW = addr_bits(WIDTH_B)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [WIDTH_A-1:0] a_wdata,
  output logic [WIDTH_A-1:0] a_rdata,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [WIDTH_B-1:0] b_wdata,
  output logic [WIDTH_B-1:0] b_rdata
);
  logic [ROW_AW-1:0] a_row, b_row;
  logic [ROW_W-1:0]  a_mask, a_val, a_q;
  logic [ROW_W-1:0]  b_mask, b_val, b_q;

  mixw_lane #(.W(WIDTH_A)) u_lane_a (
    .clk(clk), .rst(rst), .en(a_en), .addr(a_addr), .wdata(a_wdata),
    .row_q(a_q), .row_idx(a_row), .row_mask(a_mask), .row_val(a_val),
    .rdata(a_rdata)
  );

  mixw_lane #(.W(WIDTH_B)) u_lane_b (
    .clk(clk), .rst(rst), .en(b_en), .addr(b_addr), .wdata(b_wdata),
    .row_q(b_q), .row_idx(b_row), .row_mask(b_mask), .row_val(b_val),
    .rdata(b_rdata)
  );

  mixw_store #(.ROWS(ROW_CNT), .RW(ROW_W)) u_store (
    .clk(clk), .rst(rst),
    .a_rd(a_en), .a_wr(a_en && a_we), .a_row(a_row), .a_mask(a_mask),
    .a_val(a_val), .a_q(a_q),
    .b_rd(b_en), .b_wr(b_en && b_we), .b_row(b_row), .b_mask(b_mask),
    .b_val(b_val), .b_q(b_q)
  );
endmodule

// File: tb/sim_mixw_dpram.sv
module sim_mixw_dpram;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        a_en, a_we;
    logic [8:0]  a_addr;
    logic [35:0] a_wd;
    logic        b_en, b_we;
    logic [10:0] b_addr;
    logic [8:0]  b_wd;
    logic        ca;
    logic [35:0] ea;
    logic        cb;
    logic [8:0]  eb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    // R2 R3: wide write of row 5
    '{1'b1,1'b1,9'd5,36'h987654321, 1'b0,1'b0,11'd0,9'h000, 1'b0,36'h0,          1'b0,9'h000},
    // R4 R3: slice 0 of row 5 with parity bit 0
    '{1'b1,1'b0,9'd5,36'h0,         1'b1,1'b0,11'd20,9'h000, 1'b1,36'h987654321, 1'b1,9'h121},
    // R5 hold on A, R2 top slice
    '{1'b0,1'b0,9'd0,36'h0,         1'b1,1'b0,11'd23,9'h000, 1'b1,36'h987654321, 1'b1,9'h187},
    '{1'b1,1'b0,9'd5,36'h0,         1'b1,1'b0,11'd22,9'h000, 1'b1,36'h987654321, 1'b1,9'h065},
    // R6 read-first on B, R7 A sees old data
    '{1'b1,1'b0,9'd5,36'h0,         1'b1,1'b1,11'd21,9'h1AB, 1'b1,36'h987654321, 1'b1,9'h043},
    '{1'b1,1'b1,9'd8,36'h011223344, 1'b1,1'b0,11'd21,9'h000, 1'b0,36'h0,          1'b1,9'h1AB},
    // R10 both ports write different rows
    '{1'b1,1'b1,9'd7,36'h5A5A5A5A5, 1'b1,1'b1,11'd34,9'h1FF, 1'b0,36'h0,          1'b1,9'h022},
    '{1'b1,1'b0,9'd8,36'h0,         1'b1,1'b0,11'd28,9'h000, 1'b1,36'h411FF3344, 1'b1,9'h1A5},
    '{1'b1,1'b0,9'd7,36'h0,         1'b1,1'b0,11'd29,9'h000, 1'b1,36'h5A5A5A5A5, 1'b1,9'h0A5},
    // R5 hold on B
    '{1'b1,1'b0,9'd8,36'h0,         1'b0,1'b0,11'd0,9'h000,  1'b1,36'h411FF3344, 1'b1,9'h0A5},
    // R5 A write with enable low
    '{1'b0,1'b1,9'd5,36'h0,         1'b1,1'b0,11'd20,9'h000, 1'b1,36'h411FF3344, 1'b1,9'h121},
    // R5 B write with enable low, row 5 unchanged
    '{1'b1,1'b0,9'd5,36'h0,         1'b0,1'b1,11'd20,9'h000, 1'b1,36'hB8765AB21, 1'b1,9'h121},
    '{1'b1,1'b1,9'd511,36'hF0F0F0F0F,1'b1,1'b0,11'd20,9'h000,1'b0,36'h0,          1'b1,9'h121},
    // R1 top addresses of both ports
    '{1'b1,1'b0,9'd511,36'h0,       1'b1,1'b0,11'd2047,9'h000,1'b1,36'hF0F0F0F0F,1'b1,9'h10F},
    '{1'b0,1'b0,9'd0,36'h0,         1'b1,1'b0,11'd2044,9'h000,1'b1,36'hF0F0F0F0F,1'b1,9'h10F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   total = 0;
  int   bad   = 0;

  logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [8:0]  a_addr = '0;
  logic [35:0] a_wdata = '0, a_rdata;
  logic [10:0] b_addr = '0;
  logic [8:0]  b_wdata = '0, b_rdata;

  logic        x_en = 0, x_we = 0, y_en = 0, y_we = 0;
  logic [8:0]  x_addr = '0;
  logic [35:0] x_wdata = '0, x_rdata;
  logic [12:0] y_addr = '0;
  logic [1:0]  y_wdata = '0, y_rdata;

  always #(CLK_P/2) clk = ~clk;

  mixw_dpram u0 (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  mixw_dpram #(.WIDTH_A(36), .WIDTH_B(2)) u1 (
    .clk(clk), .rst(rst),
    .a_en(x_en), .a_we(x_we), .a_addr(x_addr), .a_wdata(x_wdata), .a_rdata(x_rdata),
    .b_en(y_en), .b_we(y_we), .b_addr(y_addr), .b_wdata(y_wdata), .b_rdata(y_rdata)
  );

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state
    step();
    step();
    chk("R9 reset A output", a_rdata, 36'h0);
    chk("R9 reset B output", {27'h0, b_rdata}, 36'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1 port address widths
    chk("R1 9-bit port address width", 36'($bits(b_addr)), 36'd11);
    chk("R1 2-bit port address width", 36'($bits(y_addr)), 36'd13);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_en = VT[i].a_en; a_we = VT[i].a_we; a_addr = VT[i].a_addr; a_wdata = VT[i].a_wd;
      b_en = VT[i].b_en; b_we = VT[i].b_we; b_addr = VT[i].b_addr; b_wdata = VT[i].b_wd;
      step();
      if (VT[i].ca) chk($sformatf("R2 R4 R5 R6 R7 table A step %0d", i), a_rdata, VT[i].ea);
      if (VT[i].cb) chk($sformatf("R2 R3 R5 R6 R10 table B step %0d", i), {27'h0, b_rdata}, {27'h0, VT[i].eb});
    end

    // R9: reset while both ports read, then content survives
    @(negedge clk);
    rst = 1'b1; a_en = 1; a_we = 0; a_addr = 9'd5; b_en = 1; b_we = 0; b_addr = 11'd21;
    step();
    chk("R9 reset clears A", a_rdata, 36'h0);
    chk("R9 reset clears B", {27'h0, b_rdata}, 36'h0);
    @(negedge clk);
    rst = 1'b0;
    step();
    chk("R9 content kept A", a_rdata, 36'hB8765AB21);
    chk("R9 content kept B", {27'h0, b_rdata}, 36'h1AB);
    @(negedge clk);
    a_en = 0; b_en = 0;

    // R8 R2 on the 36/2 instance
    @(negedge clk);
    x_en = 1; x_we = 1; x_addr = 9'd3; x_wdata = 36'hF00000000;
    step();
    @(negedge clk);
    x_en = 0; x_we = 0;
    y_en = 1; y_we = 1; y_addr = 13'd53; y_wdata = 2'b11;
    step();
    @(negedge clk);
    y_we = 0; y_addr = 13'd52;
    x_en = 1; x_addr = 9'd3;
    step();
    chk("R8 R2 parity kept, slice 5 placed", x_rdata, 36'hF00000C00);
    chk("R2 neighbour slice 4 clear", {34'h0, y_rdata}, 36'h0);
    @(negedge clk);
    x_en = 0; y_addr = 13'd53;
    step();
    chk("R8 narrow read back of slice 5", {34'h0, y_rdata}, 36'h3);
    @(negedge clk);
    y_addr = 13'd63;
    step();
    chk("R8 parity not visible in top slice", {34'h0, y_rdata}, 36'h0);
    @(negedge clk);
    y_en = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule